// File: doc/BRIEF.md
# Three-Operand Compare-and-Set Unit

This unit is an ALU slice that compares two 64-bit signed operands and produces a register-file write value instead of a status flag. The second operand comes either from a register or from a small immediate with zero extension. One of four conditions is evaluated: equal, not-equal, signed greater-than and signed greater-or-equal. A swap control reverses the operands before the compare, so less-than and less-or-equal use the same comparator.

The write value depends on a result mode. Flag mode writes 1 or 0. Zero-or-set mode writes a chosen value when the condition holds and zero when it does not. Set-or-keep mode writes the chosen value when the condition holds and passes through the destination's previous contents when it does not. The chosen value is either a third register operand or an 8-bit immediate with zero extension.

The result is registered. It appears one clock after an accepted request, together with a one-cycle valid strobe.

Top module: `cmpset_unit`

## Requirements
- R1: With cond_sel=0 (EQ) the condition holds when the two compared operands are equal. With cond_sel=1 (NE) it holds when they differ.
- R2: With cond_sel=2 (GT) and cond_sel=3 (GE) the operands are compared as 64-bit two's-complement signed values. This includes the most-negative and most-positive values.
- R3: When swap_ops=1 the first and second compare operands are exchanged before evaluation, so GT yields "less-than" and GE yields "less-or-equal".
- R4: When use_imm=1 the second compare operand is imm_cmp (5 bits) zero-extended to 64 bits in place of src_b.
- R5: With res_mode=0 (and the reserved res_mode=3) the result is 1 when the condition holds and 0 otherwise.
- R6: With res_mode=1 (zero-or-set) the result is the true value when the condition holds, else 0.
- R7: With res_mode=2 (set-or-keep) the result is the true value when the condition holds, else dst_old.
- R8: The true value is src_c when val_imm=0. When val_imm=1 it is imm_val (8 bits) zero-extended to 64 bits.
- R9: A request with in_valid=1 at a rising edge makes out_valid=1 and out_data equal to its result after that same edge, for exactly one cycle.
- R10: Synchronous reset clears out_valid and out_data to 0. In cycles without a request out_valid is 0 and out_data holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| cond_sel | input | 2 | 0 EQ, 1 NE, 2 GT, 3 GE |
| swap_ops | input | 1 | Exchange compare operands |
| use_imm | input | 1 | Second compare operand from imm_cmp |
| res_mode | input | 2 | 0 flag, 1 zero-or-set, 2 set-or-keep, 3 flag |
| val_imm | input | 1 | True value from imm_val instead of src_c |
| src_a | input | 64 | First compare operand |
| src_b | input | 64 | Second compare operand (register form) |
| imm_cmp | input | 5 | Compare immediate, zero-extended |
| src_c | input | 64 | True value (register form) |
| imm_val | input | 8 | True value immediate, zero-extended |
| dst_old | input | 64 | Current destination contents |
| out_valid | output | 1 | Result strobe |
| out_data | output | 64 | Registered result |

## Verification
The properties assume that in_valid is held low while rst is asserted. Without that, the first post-reset cycle would relate out_valid to a request that was never accepted. They also assume that control and data inputs are settled at the edge that samples in_valid. The stimulus satisfies both assumptions: it holds in_valid low through reset and changes every input only on the falling clock edge. Random requests draw operands from a pool biased toward equal pairs, the signed extremes, minus one and small values that overlap the 5-bit immediate range.

// File: rtl/cmpset_pkg.sv
`timescale 1ns/1ps
package cmpset_pkg;
  typedef enum logic [1:0] {
    CND_EQ = 2'd0,
    CND_NE = 2'd1,
    CND_GT = 2'd2,
    CND_GE = 2'd3
  } cond_e;

  typedef enum logic [1:0] {
    RM_FLAG = 2'd0,
    RM_ZOS  = 2'd1,
    RM_SOK  = 2'd2,
    RM_RSV  = 2'd3
  } mode_e;
endpackage

// File: rtl/cmpset_opsel.sv
`timescale 1ns/1ps
module cmpset_opsel #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 5
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [IMM_W-1:0]  imm_in,
  input  logic              use_imm,
  input  logic              swap,
  output logic [DATA_W-1:0] x_out,
  output logic [DATA_W-1:0] y_out
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] b_sel;

  generate
    if (PAD_W > 0) begin : g_pad
      assign imm_ext = {{PAD_W{1'b0}}, imm_in};
    end else begin : g_nopad
      assign imm_ext = imm_in[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    b_sel = use_imm ? imm_ext : b_in;
    if (swap) begin
      x_out = b_sel;
      y_out = a_in;
    end else begin
      x_out = a_in;
      y_out = b_sel;
    end
  end
endmodule

// File: rtl/cmpset_cmp.sv
`timescale 1ns/1ps
module cmpset_cmp
  import cmpset_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  cond_e             cond,
  output logic              hit
);
  logic eq_w;
  logic gt_w;

  always_comb begin
    eq_w = (x == y);
    gt_w = ($signed(x) > $signed(y));
    unique case (cond)
      CND_EQ:  hit = eq_w;
      CND_NE:  hit = !eq_w;
      CND_GT:  hit = gt_w;
      default: hit = gt_w | eq_w;
    endcase
  end
endmodule

// File: rtl/cmpset_result.sv
`timescale 1ns/1ps
module cmpset_result
  import cmpset_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int VIMM_W = 8
) (
  input  mode_e             mode,
  input  logic              hit,
  input  logic              val_imm,
  input  logic [DATA_W-1:0] c_in,
  input  logic [VIMM_W-1:0] vimm_in,
  input  logic [DATA_W-1:0] old_in,
  output logic [DATA_W-1:0] res
);
  localparam int PAD_W = DATA_W - VIMM_W;

  logic [DATA_W-1:0] vimm_ext;
  logic [DATA_W-1:0] tval;
  logic [DATA_W-1:0] flag_val;

  generate
    if (PAD_W > 0) begin : g_pad
      assign vimm_ext = {{PAD_W{1'b0}}, vimm_in};
    end else begin : g_nopad
      assign vimm_ext = vimm_in[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    tval     = val_imm ? vimm_ext : c_in;
    flag_val = '0;
    flag_val[0] = hit;
    unique case (mode)
      RM_ZOS:  res = hit ? tval : '0;
      RM_SOK:  res = hit ? tval : old_in;
      default: res = flag_val;
    endcase
  end
endmodule

// File: rtl/cmpset_unit.sv
`timescale 1ns/1ps
module cmpset_unit
  import cmpset_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 5,
  parameter int VIMM_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        cond_sel,
  input  logic              swap_ops,
  input  logic              use_imm,
  input  logic [1:0]        res_mode,
  input  logic              val_imm,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm_cmp,
  input  logic [DATA_W-1:0] src_c,
  input  logic [VIMM_W-1:0] imm_val,
  input  logic [DATA_W-1:0] dst_old,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [DATA_W-1:0] cmp_x;
  logic [DATA_W-1:0] cmp_y;
  logic              cmp_hit;
  logic [DATA_W-1:0] res_w;

  cmpset_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) opsel_i (
    .a_in    (src_a),
    .b_in    (src_b),
    .imm_in  (imm_cmp),
    .use_imm (use_imm),
    .swap    (swap_ops),
    .x_out   (cmp_x),
    .y_out   (cmp_y)
  );

  cmpset_cmp #(.DATA_W(DATA_W)) cmp_i (
    .x    (cmp_x),
    .y    (cmp_y),
    .cond (cond_e'(cond_sel)),
    .hit  (cmp_hit)
  );

  cmpset_result #(.DATA_W(DATA_W), .VIMM_W(VIMM_W)) res_i (
    .mode    (mode_e'(res_mode)),
    .hit     (cmp_hit),
    .val_imm (val_imm),
    .c_in    (src_c),
    .vimm_in (imm_val),
    .old_in  (dst_old),
    .res     (res_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= res_w;
    end
  end
endmodule

// File: rtl/cmpset_unit_chk.sv
`timescale 1ns/1ps
module cmpset_unit_chk #(
  parameter int DATA_W = 64,
  parameter int VIMM_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        cond_sel,
  input logic              swap_ops,
  input logic              use_imm,
  input logic [1:0]        res_mode,
  input logic              val_imm,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [DATA_W-1:0] src_c,
  input logic [VIMM_W-1:0] imm_val,
  input logic [DATA_W-1:0] dst_old,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  logic [DATA_W-1:0] tval_c;
  assign tval_c = val_imm ? {{(DATA_W-VIMM_W){1'b0}}, imm_val} : src_c;

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data)));

  // R5
  flag_binary_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (res_mode == 2'd0 || res_mode == 2'd3)) |=>
      (out_data[DATA_W-1:1] == '0));

  // R6
  zos_range_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && res_mode == 2'd1) |=>
      (out_data == '0 || out_data == $past(tval_c)));

  // R7
  sok_range_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && res_mode == 2'd2) |=>
      (out_data == $past(dst_old) || out_data == $past(tval_c)));

  // R1
  eq_same_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && res_mode == 2'd0 && cond_sel == 2'd0 && !use_imm && src_a == src_b) |=>
      (out_data == {{(DATA_W-1){1'b0}}, 1'b1}));

  // R2
  ge_same_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && res_mode == 2'd0 && cond_sel == 2'd3 && !use_imm && !swap_ops && src_a == src_b) |=>
      (out_data == {{(DATA_W-1){1'b0}}, 1'b1}));
endmodule

bind cmpset_unit cmpset_unit_chk #(.DATA_W(DATA_W), .VIMM_W(VIMM_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .cond_sel  (cond_sel),
  .swap_ops  (swap_ops),
  .use_imm   (use_imm),
  .res_mode  (res_mode),
  .val_imm   (val_imm),
  .src_a     (src_a),
  .src_b     (src_b),
  .src_c     (src_c),
  .imm_val   (imm_val),
  .dst_old   (dst_old),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/cmpset_unit_tb_top.sv
`timescale 1ns/1ps
module cmpset_unit_tb_top;
  localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  cond_sel = '0;
  logic        swap_ops = 1'b0;
  logic        use_imm = 1'b0;
  logic [1:0]  res_mode = '0;
  logic        val_imm = 1'b0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [4:0]  imm_cmp = '0;
  logic [63:0] src_c = '0;
  logic [7:0]  imm_val = '0;
  logic [63:0] dst_old = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmpset_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cond_sel(cond_sel),
    .swap_ops(swap_ops), .use_imm(use_imm), .res_mode(res_mode),
    .val_imm(val_imm), .src_a(src_a), .src_b(src_b), .imm_cmp(imm_cmp),
    .src_c(src_c), .imm_val(imm_val), .dst_old(dst_old),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] model(
    input logic [1:0] c, input logic sw, input logic ui, input logic [1:0] m,
    input logic vi, input logic [63:0] a, input logic [63:0] b,
    input logic [4:0] ib, input logic [63:0] cc, input logic [7:0] iv,
    input logic [63:0] od);
    logic [63:0] bb, x, y, tv;
    logic h;
    bb = ui ? {59'd0, ib} : b;
    x = sw ? bb : a;
    y = sw ? a : bb;
    case (c)
      2'd0: h = (x == y);
      2'd1: h = (x != y);
      2'd2: h = ($signed(x) > $signed(y));
      default: h = ($signed(x) >= $signed(y));
    endcase
    tv = vi ? {56'd0, iv} : cc;
    case (m)
      2'd1: return h ? tv : 64'd0;
      2'd2: return h ? tv : od;
      default: return {63'd0, h};
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input string req, input logic [1:0] c, input logic sw,
    input logic ui, input logic [1:0] m, input logic vi, input logic [63:0] a,
    input logic [63:0] b, input logic [4:0] ib, input logic [63:0] cc,
    input logic [7:0] iv, input logic [63:0] od);
    cond_sel = c; swap_ops = sw; use_imm = ui; res_mode = m; val_imm = vi;
    src_a = a; src_b = b; imm_cmp = ib; src_c = cc; imm_val = iv; dst_old = od;
    in_valid = 1'b1;
    @(negedge clk);
    check({req, " R9 valid"}, {63'd0, out_valid}, 64'd1);
    check(req, out_data, model(c, sw, ui, m, vi, a, b, ib, cc, iv, od));
    in_valid = 1'b0;
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 8)
      0: return MINV;
      1: return MAXV;
      2: return ONES;
      3: return 64'd0;
      4: return 64'($urandom % 34);
      default: return {32'($urandom), 32'($urandom)};
    endcase
  endfunction

  initial begin
    logic [63:0] last;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset valid", {63'd0, out_valid}, 64'd0);
    check("R10 reset data", out_data, 64'd0);

    op("R1 eq same",   2'd0, 0, 0, 2'd0, 0, 64'd77, 64'd77, 0, 0, 0, 0);
    op("R1 ne same",   2'd1, 0, 0, 2'd0, 0, 64'd77, 64'd77, 0, 0, 0, 0);
    op("R1 ne diff",   2'd1, 0, 0, 2'd0, 0, MINV, MAXV, 0, 0, 0, 0);
    op("R2 gt min>max",2'd2, 0, 0, 2'd0, 0, MINV, MAXV, 0, 0, 0, 0);
    op("R2 gt max>min",2'd2, 0, 0, 2'd0, 0, MAXV, MINV, 0, 0, 0, 0);
    op("R2 gt -1>0",   2'd2, 0, 0, 2'd0, 0, ONES, 64'd0, 0, 0, 0, 0);
    op("R2 ge equal",  2'd3, 0, 0, 2'd0, 0, MINV, MINV, 0, 0, 0, 0);
    op("R3 lt",        2'd2, 1, 0, 2'd0, 0, 64'd1, 64'd5, 0, 0, 0, 0);
    op("R3 le equal",  2'd3, 1, 0, 2'd0, 0, MAXV, MAXV, 0, 0, 0, 0);
    op("R3 lt false",  2'd2, 1, 0, 2'd0, 0, MAXV, MINV, 0, 0, 0, 0);
    op("R4 eq imm0",   2'd0, 0, 1, 2'd0, 0, 64'd0, ONES, 5'd0, 0, 0, 0);
    op("R4 gt imm0",   2'd2, 0, 1, 2'd0, 0, ONES, 64'd0, 5'd0, 0, 0, 0);
    op("R4 zext imm",  2'd0, 0, 1, 2'd0, 0, ONES, ONES, 5'd31, 0, 0, 0);
    op("R4 gt imm31",  2'd2, 0, 1, 2'd0, 0, 64'd32, 64'd99, 5'd31, 0, 0, 0);
    op("R5 mode3",     2'd0, 0, 0, 2'd3, 0, 64'd5, 64'd5, 0, ONES, 8'hAA, ONES);
    op("R6 zos true",  2'd1, 0, 0, 2'd1, 0, 64'd1, 64'd2, 0, 64'hDEAD_BEEF_0123_4567, 0, ONES);
    op("R6 zos false", 2'd1, 0, 0, 2'd1, 0, 64'd2, 64'd2, 0, 64'hDEAD_BEEF_0123_4567, 0, ONES);
    op("R7 sok false", 2'd2, 0, 0, 2'd2, 0, MINV, 64'd0, 0, ONES, 0, 64'h1234_5678_9ABC_DEF0);
    op("R7 sok true",  2'd3, 0, 0, 2'd2, 0, 64'd0, 64'd0, 0, 64'h55, 0, 64'h1234_5678_9ABC_DEF0);
    op("R8 imm true",  2'd0, 0, 0, 2'd1, 1, 64'd3, 64'd3, 0, ONES, 8'hFF, 0);
    op("R8 imm sok",   2'd1, 0, 1, 2'd2, 1, 64'd9, 0, 5'd9, ONES, 8'h80, 64'd7);

    last = out_data;
    @(negedge clk);
    check("R10 idle valid", {63'd0, out_valid}, 64'd0);
    check("R10 idle hold", out_data, last);

    for (int i = 0; i < 600; i++) begin
      logic [63:0] a, b;
      a = pick();
      b = ($urandom % 4 == 0) ? a : pick();
      op("R1 R2 R3 R4 R5 R6 R7 R8 random", 2'($urandom), 1'($urandom), 1'($urandom),
         2'($urandom), 1'($urandom), a, b, 5'($urandom), pick(), 8'($urandom), pick());
      if ($urandom % 5 == 0) begin
        last = out_data;
        @(negedge clk);
        check("R10 gap hold", out_data, last);
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule